// File: doc/BRIEF.md
# Global-Pointer-Relative Memory Instruction Decoder

This block decodes one group of 32-bit instructions whose memory address or
sum is formed from a fixed global-pointer register and an unsigned immediate.
The group's instruction word is presented at the input. The block returns a
micro-operation descriptor that a later pipeline stage carries out. The
descriptor holds the operation kind, access size, signedness, the data
register, the base register, the byte offset after alignment masking, a
register write enable and a flag that asks for 32-bit sign extension of an
add result. A reserved-instruction flag marks encodings that must trap.

The decoder performs no memory access, owns no register file and has no adder.
A 3-bit sub-opcode picks the operation. In the halfword and coprocessor
sub-groups, the low bits of the offset act as a second-level selector and are
cleared before the offset is used. The descriptor leaves the block either
combinationally or through one register stage, chosen by a parameter.

Top module: `gp_mem_decoder`

## Requirements
- R1: Sub-opcode field instr[20:18] = 0 gives a signed byte load, 1 gives a byte store and 2 gives an unsigned byte load. Each uses size 0, and the offset equals instr[17:0] unchanged.
- R2: Sub-opcode 3 is an add-immediate (kind 3, size 0, unsigned) with offset instr[17:0]. Write enable is high unless the register field is 0, in which case the operation is a no-op with write enable low.
- R3: ext32 is 1 exactly for sub-opcode 3 when XLEN is 64 and wrap_i is 1, including when the offset is zero. Otherwise it is 0.
- R4: Sub-opcode 4 is a halfword load (size 1). instr[0]=0 makes it signed and instr[0]=1 makes it unsigned. Offset bit 0 is cleared.
- R5: Sub-opcode 5 with instr[0]=0 is a halfword store (kind 2, size 1) with offset bit 0 cleared. With instr[0]=1 it is a reserved instruction.
- R6: Sub-opcode 6 is a coprocessor transfer with offset bits 1:0 cleared. instr[1:0] = 0 selects a word load (kind 4, size 2), 1 a double load (kind 4, size 3), 2 a word store (kind 5, size 2) and 3 a double store (kind 5, size 3).
- R7: Sub-opcode 7 is a reserved instruction.
- R8: When the reserved-instruction flag is set, every other descriptor field is zero.
- R9: For every non-reserved encoding, the base register is GP_REG (28) and the data register is instr[25:21].
- R10: With REG_OUT=1, the descriptor appears one clock after the instruction, and reset drives every output to zero. With REG_OUT=0, the descriptor is combinational.
- R11: Write enable is 1 for every integer and coprocessor load and 0 for every store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register and the checks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction word of the group |
| wrap_i | input | 1 | Address-wrap mode flag |
| kind_o | output | 3 | 0 none, 1 load, 2 store, 3 add-immediate, 4 coprocessor load, 5 coprocessor store |
| size_o | output | 2 | 0 byte, 1 halfword, 2 word, 3 double |
| signed_o | output | 1 | Sign-extend the loaded value |
| reg_o | output | 5 | Data (destination or source) register |
| base_o | output | 5 | Base register |
| offset_o | output | 18 | Zero-extended byte offset after alignment masking |
| wen_o | output | 1 | Register write enable |
| ext32_o | output | 1 | Sign-extend the add result from bit 31 |
| ri_o | output | 1 | Reserved-instruction exception |

## Verification
The bench walks every sub-opcode with all four values of the low selector bits, both wrap settings, and register fields 0, 5 and 31. A decoder that forgot to clear the selector bits would put odd or unaligned offsets on halfword and coprocessor accesses. One that mixed up the halfword signedness bit would sign-extend unsigned loads. The zero-offset add-immediate under wrap mode targets the case where the extension is skipped because the sum seems trivial. The register-0 add-immediate targets a decoder that writes register 0. The halfword-store selector 1 and sub-opcode 7 show whether a design decodes a reserved slot as a real store or leaves stale fields beside the trap flag.

// File: rtl/gpls_pkg.sv
package gpls_pkg;

   localparam int unsigned OFF_W = 18;
   localparam int unsigned REG_W = 5;

   typedef enum logic [2:0] {
      K_NONE   = 3'd0,
      K_LOAD   = 3'd1,
      K_STORE  = 3'd2,
      K_ADDI   = 3'd3,
      K_FLOAD  = 3'd4,
      K_FSTORE = 3'd5
   } gpls_kind_e;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } gpls_size_e;

   typedef struct packed {
      gpls_kind_e             kind;
      gpls_size_e             size;
      logic                   sgn;
      logic [REG_W-1:0]       rreg;
      logic [REG_W-1:0]       base;
      logic [OFF_W-1:0]       off;
      logic                   wen;
      logic                   ext32;
      logic                   ri;
   } gpls_desc_t;

endpackage

// File: rtl/gpls_class.sv
module gpls_class
   import gpls_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [2:0]  sub_i,
   input  logic [1:0]  sel_i,
   input  logic        rt_zero_i,
   input  logic        wrap_i,
   output gpls_kind_e  kind_o,
   output gpls_size_e  size_o,
   output logic        sgn_o,
   output logic        wen_o,
   output logic        ext32_o,
   output logic        ri_o,
   output logic [1:0]  clr_o
);

   localparam bit WIDE = (XLEN == 64);

   always_comb begin
      kind_o  = K_NONE;
      size_o  = SZ_B;
      sgn_o   = 1'b0;
      wen_o   = 1'b0;
      ext32_o = 1'b0;
      ri_o    = 1'b0;
      clr_o   = 2'b00;
      unique case (sub_i)
         3'd0: begin
            kind_o = K_LOAD;
            sgn_o  = 1'b1;
            wen_o  = 1'b1;
         end
         3'd1: kind_o = K_STORE;
         3'd2: begin
            kind_o = K_LOAD;
            wen_o  = 1'b1;
         end
         3'd3: begin
            kind_o  = K_ADDI;
            wen_o   = ~rt_zero_i;
            ext32_o = WIDE & wrap_i;
         end
         3'd4: begin
            kind_o = K_LOAD;
            size_o = SZ_H;
            sgn_o  = ~sel_i[0];
            wen_o  = 1'b1;
            clr_o  = 2'b01;
         end
         3'd5: begin
            if (sel_i[0]) begin
               ri_o = 1'b1;
            end else begin
               kind_o = K_STORE;
               size_o = SZ_H;
               clr_o  = 2'b01;
            end
         end
         3'd6: begin
            kind_o = sel_i[1] ? K_FSTORE : K_FLOAD;
            size_o = sel_i[0] ? SZ_D : SZ_W;
            wen_o  = ~sel_i[1];
            clr_o  = 2'b11;
         end
         default: ri_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/gpls_align.sv
module gpls_align #(
   parameter int unsigned OFF_W = 18
) (
   input  logic [OFF_W-1:0] raw_i,
   input  logic [1:0]       clr_i,
   input  logic             kill_i,
   output logic [OFF_W-1:0] off_o
);

   for (genvar i = 0; i < OFF_W; i++) begin : g_bit
      if (i < 2) begin : g_low
         assign off_o[i] = raw_i[i] & ~clr_i[i] & ~kill_i;
      end else begin : g_high
         assign off_o[i] = raw_i[i] & ~kill_i;
      end
   end

endmodule

// File: rtl/gpls_stage.sv
module gpls_stage
   import gpls_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  gpls_desc_t d_i,
   output gpls_desc_t q_o
);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_o <= '0;
         else         q_o <= d_i;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign q_o = d_i;
   end

endmodule

// File: rtl/gp_mem_decoder.sv
module gp_mem_decoder
   import gpls_pkg::*;
#(
   parameter int unsigned XLEN    = 64,
   parameter bit          REG_OUT = 1'b0,
   parameter int unsigned GP_REG  = 28,
   parameter int unsigned IW      = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [IW-1:0]    instr_i,
   input  logic             wrap_i,
   output logic [2:0]       kind_o,
   output logic [1:0]       size_o,
   output logic             signed_o,
   output logic [REG_W-1:0] reg_o,
   output logic [REG_W-1:0] base_o,
   output logic [OFF_W-1:0] offset_o,
   output logic             wen_o,
   output logic             ext32_o,
   output logic             ri_o
);

   localparam int unsigned SUB_LSB = OFF_W;
   localparam int unsigned RT_LSB  = OFF_W + 3;
   localparam int unsigned TOP_USE = RT_LSB + REG_W;

   if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
      $error("gp_mem_decoder: XLEN must be 32 or 64");
   end
   if (GP_REG >= (1 << REG_W)) begin : g_bad_gp
      $error("gp_mem_decoder: GP_REG out of register range");
   end
   if (IW <= TOP_USE) begin : g_bad_iw
      $error("gp_mem_decoder: IW too narrow for the field layout");
   end

   logic [2:0]       sub;
   logic [REG_W-1:0] rt;
   logic             unused_major;

   assign sub          = instr_i[SUB_LSB +: 3];
   assign rt           = instr_i[RT_LSB +: REG_W];
   assign unused_major = ^instr_i[IW-1:TOP_USE];

   gpls_kind_e c_kind;
   gpls_size_e c_size;
   logic       c_sgn, c_wen, c_ext, c_ri;
   logic [1:0] c_clr;

   gpls_class #(.XLEN(XLEN)) i_class (
      .sub_i     (sub),
      .sel_i     (instr_i[1:0]),
      .rt_zero_i (rt == '0),
      .wrap_i    (wrap_i),
      .kind_o    (c_kind),
      .size_o    (c_size),
      .sgn_o     (c_sgn),
      .wen_o     (c_wen),
      .ext32_o   (c_ext),
      .ri_o      (c_ri),
      .clr_o     (c_clr)
   );

   logic [OFF_W-1:0] c_off;

   gpls_align #(.OFF_W(OFF_W)) i_align (
      .raw_i  (instr_i[OFF_W-1:0]),
      .clr_i  (c_clr),
      .kill_i (c_ri),
      .off_o  (c_off)
   );

   gpls_desc_t d_c, d_q;

   always_comb begin
      d_c.kind  = c_kind;
      d_c.size  = c_size;
      d_c.sgn   = c_sgn;
      d_c.rreg  = c_ri ? '0 : rt;
      d_c.base  = c_ri ? '0 : REG_W'(GP_REG);
      d_c.off   = c_off;
      d_c.wen   = c_wen;
      d_c.ext32 = c_ext;
      d_c.ri    = c_ri;
   end

   gpls_stage #(.REG_OUT(REG_OUT)) i_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (d_c),
      .q_o    (d_q)
   );

   assign kind_o   = d_q.kind;
   assign size_o   = d_q.size;
   assign signed_o = d_q.sgn;
   assign reg_o    = d_q.rreg;
   assign base_o   = d_q.base;
   assign offset_o = d_q.off;
   assign wen_o    = d_q.wen;
   assign ext32_o  = d_q.ext32;
   assign ri_o     = d_q.ri;

   AST_RI_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ri_o |-> (kind_o == 3'd0 && !wen_o && !ext32_o && offset_o == '0 && reg_o == '0)); // R8
   AST_BASE_GP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_o != 3'd0) |-> (base_o == REG_W'(GP_REG))); // R9
   AST_HALF_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (size_o == 2'd1) |-> !offset_o[0]); // R4
   AST_FP_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_o == 3'd4 || kind_o == 3'd5) |-> (offset_o[1:0] == 2'b00)); // R6
   AST_EXT_ADDI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext32_o |-> (kind_o == 3'd3)); // R3
   AST_STORE_NOWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_o == 3'd2 || kind_o == 3'd5) |-> !wen_o); // R11

endmodule

// File: tb/test_gp_mem_decoder.sv
module test_gp_mem_decoder;

   localparam int XLEN = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0;
   logic        wrap = 1'b0;
   logic [2:0]  kind;
   logic [1:0]  size;
   logic        sgn;
   logic [4:0]  rreg, base;
   logic [17:0] off;
   logic        wen, ext, ri;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   gp_mem_decoder #(.XLEN(XLEN), .REG_OUT(1'b1)) i_gp_mem_decoder (
      .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .wrap_i(wrap),
      .kind_o(kind), .size_o(size), .signed_o(sgn), .reg_o(rreg),
      .base_o(base), .offset_o(off), .wen_o(wen), .ext32_o(ext), .ri_o(ri)
   );

   // expected descriptor {kind3,size2,sgn,reg5,base5,off18,wen,ext,ri}
   function automatic logic [36:0] model(logic [31:0] w, logic wr);
      int unsigned sub = w[20:18];
      logic [4:0]  rt  = w[25:21];
      logic [17:0] o   = w[17:0];
      int unsigned k = 0, sz = 0;
      bit sg = 0, we = 0, ex = 0, rsv = 0;
      case (sub)
         0: begin k = 1; sg = 1; we = 1; end
         1: k = 2;
         2: begin k = 1; we = 1; end
         3: begin k = 3; we = (rt != 0); ex = (XLEN == 64) && wr; end
         4: begin k = 1; sz = 1; sg = !w[0]; we = 1; o[0] = 0; end
         5: if (w[0]) rsv = 1; else begin k = 2; sz = 1; o[0] = 0; end
         6: begin
               o[1:0] = 0;
               k  = w[1] ? 5 : 4;
               sz = w[0] ? 3 : 2;
               we = !w[1];
            end
         default: rsv = 1;
      endcase
      if (rsv) return 37'd1;
      return {3'(k), 2'(sz), sg, rt, 5'd28, o, we, ex, 1'b0};
   endfunction

   function automatic string tag_of(logic [31:0] w);
      case (w[20:18])
         3'd0, 3'd1, 3'd2: return "R1";
         3'd3: return "R2";
         3'd4: return "R4";
         3'd5: return "R5";
         3'd6: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(string req, logic [36:0] a, logic [36:0] e);
      total++;
      if (a !== e) begin
         bad++;
         $display("FAIL %s instr=%h got=%h exp=%h", req, pend_w, a, e);
      end
   endtask

   logic [31:0] pend_w;
   logic [36:0] pend_e;
   bit          have = 0;

   task automatic compare();
      logic [36:0] a;
      string t;
      a = {kind, size, sgn, rreg, base, off, wen, ext, ri};
      t = tag_of(pend_w);
      chk(t, 37'({a[36:31], a[0]}), 37'({pend_e[36:31], pend_e[0]}));
      chk(t, 37'(a[20:3]), 37'(pend_e[20:3]));
      chk("R9", 37'(a[30:21]), 37'(pend_e[30:21]));
      chk("R11", 37'(a[2]), 37'(pend_e[2]));
      chk("R3", 37'(a[1]), 37'(pend_e[1]));
      if (pend_e[0]) chk("R8", a, pend_e);
      chk("R10", a, pend_e); // one-cycle latency: value of previous instruction
   endtask

   // drive at negedge; the registered output is sampled one negedge later
   task automatic apply(logic [31:0] w, logic wr);
      @(negedge clk);
      if (have) compare();
      instr  = w;
      wrap   = wr;
      pend_w = w;
      pend_e = model(w, wr);
      have   = 1;
   endtask

   initial begin
      #(8 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      if (!done) begin
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [5:0] rts [3];
      rts[0] = 0; rts[1] = 5; rts[2] = 31;
      repeat (3) @(negedge clk);
      instr = 32'h0010_0003;
      @(negedge clk);
      pend_w = instr;
      chk("R10", {kind, size, sgn, rreg, base, off, wen, ext, ri}, 37'd0); // reset state
      rst_n = 1'b1;
      for (int s = 0; s < 8; s++)
         for (int sel = 0; sel < 4; sel++)
            for (int r = 0; r < 3; r++)
               for (int wr = 0; wr < 2; wr++) begin
                  logic [17:0] o;
                  o = (r == 0) ? 18'(sel) : {16'($urandom), 2'(sel)};
                  apply({6'h11, rts[r][4:0], 3'(s), o}, 1'(wr));
               end
      // zero-offset add-immediate with wrap set (R3)
      apply({6'h11, 5'd7, 3'd3, 18'd0}, 1'b1);
      apply({6'h11, 5'd7, 3'd3, 18'd0}, 1'b0);
      for (int n = 0; n < 3000; n++) apply($urandom, 1'($urandom));
      @(negedge clk);
      compare();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule